// File: doc/BRIEF.md
# Symmetric Distributed-Arithmetic Dot Product

This block multiplies four signed input samples by a fixed, mirror-symmetric weight vector (outer weight 13, inner weight 11) and sums the products. Since the outer two weights are equal and the inner two weights are equal, the block adds the outer pair of samples and the inner pair of samples before any table lookup. The two pre-added sums then pass bit-serially through a four-word table, least significant bit first. The table holds every combination of the two weights: 0, outer, inner, outer + inner.

A single-cycle `start` pulse captures the four samples. On each of the following bit-cycles, the shift-accumulator takes one table word. When the final (sign) bit of the sums is processed, the table word is subtracted rather than added, which gives the correct two's-complement result. A one-cycle `done` pulse then marks the full-precision result. The result holds until the next operation completes. The block runs one operation at a time and ignores `start` while a computation is in flight.

Two lookup variants can be selected by a parameter: a case-decoded table, or a table-free form that builds the word from the two weights with one adder. Both variants produce the same results.

Top module: `sym_da_dot`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: When `done` is 1, `result` equals 13·x0 + 11·x1 + 11·x2 + 13·x3 for the samples captured with the accepted `start`.
- R3: Samples are 4-bit two's complement, from -8 to 7. The extremes are exact: all samples at 7 give 336 and all at -8 give -384, in a 10-bit signed `result`.
- R4: A `start` sampled high while idle is accepted. `done` is then sampled high exactly 5 clock edges later (one edge per bit of the 5-bit pre-added sums), and at no other time.
- R5: `done` is high for exactly one cycle per operation.
- R6: `result` changes only on the edge that raises `done`. Between operations it holds its value.
- R7: A `start` raised while an operation is in flight has no effect. The running result, its timing and the count of `done` pulses are unchanged.
- R8: A `start` presented in the cycle in which `done` is high is accepted, so operations can run back to back.
- R9: The table variant (USE_TABLE=1) and the table-free adder variant (USE_TABLE=0) give identical results for the same samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture samples and begin an operation when idle |
| x0 | input | 4 | Sample 0, signed, outer weight |
| x1 | input | 4 | Sample 1, signed, inner weight |
| x2 | input | 4 | Sample 2, signed, inner weight |
| x3 | input | 4 | Sample 3, signed, outer weight |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 10 | Signed dot product |

## Verification
The bound checker checks four things on every cycle:
- the exact latency from an accepted start to `done`;
- the single-cycle width of `done`;
- that `result` holds between completions;
- that each completed result equals a direct multiply-accumulate of the samples captured at acceptance.

Three behaviours can only be shown by the bench's scenarios: a start ignored mid-operation leaving no trace at the ports, back-to-back acceptance in the `done` cycle, and agreement between the two lookup variants. The bench also sweeps 4096 sample combinations, including both signed extremes.

// File: rtl/sym_da_pkg.sv
package sym_da_pkg;

   typedef enum logic {
      DA_IDLE = 1'b0,
      DA_RUN  = 1'b1
   } da_state_e;

   // bits needed to hold the unsigned value v
   function automatic int bits_for(input int v);
      return $clog2(v + 1);
   endfunction

endpackage

// File: rtl/sym_da_preadd.sv
module sym_da_preadd #(
   parameter int IN_W = 4
) (
   input  logic signed [IN_W-1:0] a,
   input  logic signed [IN_W-1:0] b,
   output logic signed [IN_W:0]   sum
);
   // explicit sign extension, one extra bit so the sum never wraps
   assign sum = $signed({a[IN_W-1], a}) + $signed({b[IN_W-1], b});
endmodule

// File: rtl/sym_da_lut.sv
module sym_da_lut #(
   parameter int WORD_W    = 5,
   parameter int COEF_OUT  = 13,
   parameter int COEF_IN   = 11,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic [1:0]        addr,
   output logic [WORD_W-1:0] word
);
   localparam logic [WORD_W-1:0] W_OUT = WORD_W'(COEF_OUT);
   localparam logic [WORD_W-1:0] W_IN  = WORD_W'(COEF_IN);
   localparam logic [WORD_W-1:0] W_ALL = WORD_W'(COEF_OUT + COEF_IN);

   generate
      if (USE_TABLE) begin : g_table
         // addr[0] selects the outer pair, addr[1] the inner pair
         always_comb begin
            unique case (addr)
               2'b00:   word = '0;
               2'b01:   word = W_OUT;
               2'b10:   word = W_IN;
               default: word = W_ALL;
            endcase
         end
      end else begin : g_adder
         always_comb begin
            word = (addr[0] ? W_OUT : '0) + (addr[1] ? W_IN : '0);
         end
      end
   endgenerate
endmodule

// File: rtl/sym_da_serial.sv
module sym_da_serial #(
   parameter int SUM_W  = 5,
   parameter int WORD_W = 5,
   parameter int RES_W  = 10,
   parameter int ACC_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic signed [SUM_W-1:0] s0_in,
   input  logic signed [SUM_W-1:0] s1_in,
   input  logic [WORD_W-1:0]       word,
   output logic [1:0]              addr,
   output logic                    busy,
   output logic                    done,
   output logic signed [RES_W-1:0] result
);
   import sym_da_pkg::*;

   localparam int CNT_W = (SUM_W > 1) ? $clog2(SUM_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SUM_W - 1);

   da_state_e               state;
   logic [SUM_W-1:0]        sh0, sh1;
   logic [CNT_W-1:0]        cnt;
   logic signed [ACC_W-1:0] acc, term, sum_w, acc_nx;
   logic                    sign_step;

   assign busy      = (state == DA_RUN);
   assign addr      = {sh1[0], sh0[0]};
   assign sign_step = (cnt == LAST);

   // the word enters at weight 2^SUM_W; every step halves the whole accumulator
   always_comb begin
      term   = $signed({{(ACC_W-WORD_W){1'b0}}, word}) <<< SUM_W;
      sum_w  = sign_step ? (acc - term) : (acc + term);
      acc_nx = sum_w >>> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= DA_IDLE;
         sh0    <= '0;
         sh1    <= '0;
         cnt    <= '0;
         acc    <= '0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            DA_IDLE: begin
               if (load) begin
                  sh0   <= s0_in;
                  sh1   <= s1_in;
                  cnt   <= '0;
                  acc   <= '0;
                  state <= DA_RUN;
               end
            end
            default: begin
               acc <= acc_nx;
               sh0 <= sh0 >> 1;
               sh1 <= sh1 >> 1;
               cnt <= cnt + 1'b1;
               if (sign_step) begin
                  state  <= DA_IDLE;
                  done   <= 1'b1;
                  result <= acc_nx[RES_W-1:0];
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sym_da_dot.sv
module sym_da_dot #(
   parameter int IN_W      = 4,
   parameter int COEF_OUT  = 13,
   parameter int COEF_IN   = 11,
   parameter bit USE_TABLE = 1'b1,
   localparam int RES_W    = sym_da_pkg::bits_for((COEF_OUT + COEF_IN) << IN_W) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [IN_W-1:0]  x0,
   input  logic signed [IN_W-1:0]  x1,
   input  logic signed [IN_W-1:0]  x2,
   input  logic signed [IN_W-1:0]  x3,
   output logic                    done,
   output logic signed [RES_W-1:0] result
);
   localparam int SUM_W  = IN_W + 1;
   localparam int WORD_W = sym_da_pkg::bits_for(COEF_OUT + COEF_IN);
   localparam int ACC_W  = RES_W + 2;

   if (IN_W < 2) begin : g_bad_width
      $error("sym_da_dot: IN_W must be at least 2");
   end
   if (COEF_OUT <= 0 || COEF_IN <= 0) begin : g_bad_coef
      $error("sym_da_dot: weights must be positive");
   end
   if (ACC_W <= WORD_W + SUM_W) begin : g_bad_acc
      $error("sym_da_dot: accumulator too narrow");
   end

   logic signed [IN_W-1:0]  xs [4];
   logic signed [SUM_W-1:0] psum [2];
   logic [1:0]              lut_addr;
   logic [WORD_W-1:0]       lut_word;
   logic                    seq_busy;

   assign xs[0] = x0;
   assign xs[1] = x1;
   assign xs[2] = x2;
   assign xs[3] = x3;

   // pair p folds sample p with its mirror 3-p
   for (genvar p = 0; p < 2; p++) begin : g_pair
      sym_da_preadd #(.IN_W(IN_W)) u_add (
         .a   (xs[p]),
         .b   (xs[3-p]),
         .sum (psum[p])
      );
   end

   sym_da_lut #(
      .WORD_W    (WORD_W),
      .COEF_OUT  (COEF_OUT),
      .COEF_IN   (COEF_IN),
      .USE_TABLE (USE_TABLE)
   ) u_lut (
      .addr (lut_addr),
      .word (lut_word)
   );

   sym_da_serial #(
      .SUM_W  (SUM_W),
      .WORD_W (WORD_W),
      .RES_W  (RES_W),
      .ACC_W  (ACC_W)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .s0_in  (psum[0]),
      .s1_in  (psum[1]),
      .word   (lut_word),
      .addr   (lut_addr),
      .busy   (seq_busy),
      .done   (done),
      .result (result)
   );
endmodule

// File: rtl/sym_da_chk.sv
module sym_da_chk #(
   parameter int IN_W     = 4,
   parameter int SUM_W    = 5,
   parameter int RES_W    = 10,
   parameter int COEF_OUT = 13,
   parameter int COEF_IN  = 11
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    busy,
   input logic                    done,
   input logic signed [IN_W-1:0]  x0,
   input logic signed [IN_W-1:0]  x1,
   input logic signed [IN_W-1:0]  x2,
   input logic signed [IN_W-1:0]  x3,
   input logic signed [RES_W-1:0] result
);
   int   exp_q;
   int   since;
   logic track;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q <= 0;
         since <= 0;
         track <= 1'b0;
      end else if (start && !busy) begin
         exp_q <= COEF_OUT * int'(x0) + COEF_IN * int'(x1)
                + COEF_IN * int'(x2) + COEF_OUT * int'(x3);
         since <= 0;
         track <= 1'b1;
      end else if (track) begin
         if (done) track <= 1'b0;
         else      since <= since + 1;
      end
   end

   assert_done_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (track && since == SUM_W));
   assert_done_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (track && since == SUM_W) |-> done);
   assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   assert_result_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(result) == exp_q));
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
endmodule

bind sym_da_dot sym_da_chk #(
   .IN_W     (IN_W),
   .SUM_W    (SUM_W),
   .RES_W    (RES_W),
   .COEF_OUT (COEF_OUT),
   .COEF_IN  (COEF_IN)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (seq_busy),
   .done   (done),
   .x0     (x0),
   .x1     (x1),
   .x2     (x2),
   .x3     (x3),
   .result (result)
);

// File: tb/tb_sym_da_dot.sv
`timescale 1ns/1ps
module tb_sym_da_dot;
   localparam int LAT = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic signed [3:0] x0 = '0, x1 = '0, x2 = '0, x3 = '0;
   logic done, done_alt;
   logic signed [9:0] result, result_alt;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sym_da_dot #(.USE_TABLE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .x0(x0), .x1(x1), .x2(x2), .x3(x3),
      .done(done), .result(result));

   sym_da_dot #(.USE_TABLE(1'b0)) dut_alt (
      .clk(clk), .rst_n(rst_n), .start(start),
      .x0(x0), .x1(x1), .x2(x2), .x3(x3),
      .done(done_alt), .result(result_alt));

   function automatic int mac(input int a, input int b, input int c, input int d);
      return 13 * a + 11 * b + 11 * c + 13 * d;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // caller stands just after a falling edge
   task automatic start_op(input int a, input int b, input int c, input int d);
      start = 1'b1;
      x0 = 4'(a); x1 = 4'(b); x2 = 4'(c); x3 = 4'(d);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input int n0, output int n);
      n = n0;
      while (!done && n < 20) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic run_op(input int a, input int b, input int c, input int d);
      int n;
      start_op(a, b, c, d);
      wait_done(0, n);
      check("R4 latency", n, LAT);
      check("R2 result", int'(result), mac(a, b, c, d));
      check("R9 variant match", int'(result_alt), int'(result));
      @(negedge clk);
      check("R5 done width", int'(done), 0);
   endtask

   initial begin
      int n;
      logic signed [9:0] held;
      repeat (3) @(negedge clk);
      check("R1 done after reset", int'(done), 0);
      check("R1 result after reset", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done idle", int'(done), 0);

      // R3 signed extremes
      run_op(7, 7, 7, 7);
      check("R3 max positive", int'(result), 336);
      run_op(-8, -8, -8, -8);
      check("R3 max negative", int'(result), -384);
      run_op(-8, 7, -8, 7);
      run_op(1, 0, 0, 0);
      run_op(0, 1, 0, 0);

      // R6 result holds while idle
      held = result;
      repeat (6) @(negedge clk);
      check("R6 hold idle", int'(result), int'(held));

      // R7 start while busy is ignored
      start_op(3, -2, 5, 1);
      repeat (2) @(negedge clk);
      start = 1'b1; x0 = 4'(-8); x1 = 4'(-8); x2 = 4'(-8); x3 = 4'(-8);
      @(negedge clk);
      start = 1'b0;
      wait_done(3, n);
      check("R7 latency unchanged", n, LAT);
      check("R7 result unchanged", int'(result), mac(3, -2, 5, 1));
      held = result;
      n = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (done) n++;
      end
      check("R7 no extra done", n, 0);
      check("R7 result kept", int'(result), int'(held));

      // R8 back to back
      start_op(2, 4, -6, 7);
      wait_done(0, n);
      check("R8 first result", int'(result), mac(2, 4, -6, 7));
      start_op(-1, -3, 6, -7);
      wait_done(0, n);
      check("R8 second latency", n, LAT);
      check("R8 second result", int'(result), mac(-1, -3, 6, -7));
      @(negedge clk);

      // near-exhaustive sweep: R2 R3 R9
      for (int a = -8; a < 8; a++) begin
         for (int b = -8; b < 8; b++) begin
            for (int d = -8; d < 8; d++) begin
               int c;
               c = ((a - b + d + 8 + 64) % 16) - 8;
               run_op(a, b, c, d);
            end
         end
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule